// File: doc/BRIEF.md
# Periodic Clock Calibration Unit

This block trims the rate of a 32.768 kHz timekeeping chain without touching the crystal. It sits at the divide-by-256 stage of the chain. In a few chosen seconds it either splits one stage period into two, so that second ends early, or holds the prescaler for half a period, so that second ends late. The corrections follow a repeating cycle of 64 minutes. A 5-bit magnitude N selects how many minutes at the start of that cycle carry one corrected second each, namely 2N. A sign bit selects the direction. A step of +1 speeds the clock by about 4.07 ppm. A step of -1 slows it by about 2.03 ppm, because the shortening is twice as large as the lengthening.

The unit receives a one-cycle oscillator enable (`osc_tick`) and a minute marker from the downstream time counters. It produces the corrected 128 Hz stage tick and the one-second tick, along with strobes that show each split and each swallowed count. A free-running tap counter runs alongside the prescaler. It feeds the square-wave selector and is never affected by the corrections, so the 512 Hz test output keeps its frequency whatever calibration value is loaded. Writing any clock register pulses `chain_clear`, which restarts the divider and the 64-minute cycle together.

Top module: `calib_unit`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `stage_tick`, `sec_tick`, `insert_pulse` and `blank_pulse` are low and `tap_div` is 0. A fresh second and cycle minute 0 begin at release.
- R2: An uncorrected second lasts 2^(PRE_W+STG_W) enabled oscillator ticks (32768 by default) and contains 2^STG_W stage ticks. `sec_tick` is high on the same cycle as the last of those stage ticks.
- R3: With magnitude N = `cal_cfg[MAG_W-1:0]`, exactly the minutes whose index in the cycle is below 2N have one corrected second each: the first second of the minute. A `min_tick` pulse during a second marks the next second as the first second of a new minute.
- R4: With `cal_cfg[MAG_W]` = 1 (fast), a corrected second is 2^PRE_W ticks shorter. It shows exactly one `insert_pulse`, placed at the midpoint of its first stage period, and still has 2^STG_W stage ticks.
- R5: With `cal_cfg[MAG_W]` = 0 (slow), a corrected second is 2^(PRE_W-1) ticks longer. `blank_pulse` is high for each swallowed tick, and the prescaler does not advance on those ticks.
- R6: A magnitude of 0 corrects no second, whatever the sign bit.
- R7: The cycle is 2^CYC_W minutes long and wraps back to minute 0. Its last two minutes are never corrected.
- R8: `chain_clear` restarts the prescaler, the second and the cycle position. The second that follows is minute 0 of a new cycle.
- R9: `tap_div` advances by one on every enabled oscillator tick, modulo 2^PRE_W, whatever the calibration. At default widths, bit 5 toggles at 512 Hz.
- R10: Only cycles with `osc_tick` high advance the chain. Second lengths counted in ticks are the same when the enable arrives with gaps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle enable at the 32.768 kHz oscillator rate |
| chain_clear | input | 1 | Restart divider and correction cycle (clock register write) |
| min_tick | input | 1 | Next second begins a new minute |
| cal_cfg | input | MAG_W+1 | Bit MAG_W: sign (1 fast, 0 slow); lower bits: magnitude |
| stage_tick | output | 1 | Corrected divide-by-2^PRE_W stage event |
| sec_tick | output | 1 | End of a second |
| insert_pulse | output | 1 | An extra stage event was inserted |
| blank_pulse | output | 1 | An oscillator tick was swallowed |
| tap_div | output | PRE_W | Uncorrected tap counter for square-wave selection |

## Verification
The state that is hardest to reach from the ports is the end of the correction cycle. Minutes 62 and 63 and the wrap back to minute 0 come only after an hour of timekeeping. The bench therefore shrinks all three counter widths and pulses `min_tick` once per second, so that each minute is one second long and a whole cycle passes in about two thousand clock cycles. It then sweeps every magnitude with both signs and predicts each second's tick count, insert count and blank count from the cycle index.

// File: rtl/calib_pkg.sv
package calib_pkg;

    // Direction of correction selected by the sign bit.
    typedef enum logic {
        DIR_SLOW = 1'b0,
        DIR_FAST = 1'b1
    } cal_dir_e;

    // Registered events produced by the prescaler.
    typedef struct packed {
        logic stage;
        logic second;
        logic insert;
        logic blank;
    } strobes_t;

    // A minute is corrected when its index lies below twice the magnitude.
    function automatic logic minute_in_window(input int unsigned idx,
                                              input int unsigned mag);
        return idx < (2 * mag);
    endfunction

    // Minutes of a cycle that may ever be corrected.
    function automatic int unsigned eligible_minutes(input int unsigned cyc_w);
        return (32'd1 << cyc_w) - 32'd2;
    endfunction

endpackage

// File: rtl/calib_tap_div.sv
module calib_tap_div #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         osc_tick,
    output logic [W-1:0] tap
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            tap <= '0;
        end else if (osc_tick) begin
            tap <= tap + W'(1);
        end
    end

    AST_TAP_ADVANCE: assert property (@(posedge clk) disable iff (rst) (osc_tick && !clr) |=> (tap == $past(tap) + W'(1))); // R9

endmodule

// File: rtl/calib_cycle_window.sv
module calib_cycle_window
    import calib_pkg::*;
#(
    parameter int unsigned CYC_W = 6,
    parameter int unsigned MAG_W = CYC_W - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             min_tick,
    input  logic             sec_wrap,
    input  logic             apply_done,
    input  logic [MAG_W-1:0] mag,
    output logic             act
);

    localparam int unsigned ELIG = eligible_minutes(CYC_W);

    logic [CYC_W-1:0] min_idx;
    logic [CYC_W-1:0] next_idx;
    logic             pend;
    logic             arm;

    assign next_idx = min_idx + CYC_W'(1);
    assign arm      = min_tick && minute_in_window(32'(next_idx), 32'(mag));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            min_idx <= '0;
            pend    <= 1'b0;
            act     <= (mag != '0);
        end else begin
            if (min_tick) begin
                min_idx <= next_idx;
            end
            if (sec_wrap) begin
                act  <= pend || arm;
                pend <= 1'b0;
            end else begin
                pend <= pend || arm;
                if (apply_done) begin
                    act <= 1'b0;
                end
            end
        end
    end

    AST_PEND_IN_WINDOW: assert property (@(posedge clk) disable iff (rst) $rose(pend) |-> (32'(min_idx) < ELIG)); // R7
    AST_CLEAR_ORIGIN: assert property (@(posedge clk) disable iff (rst) clr |=> ((min_idx == '0) && !pend)); // R8

endmodule

// File: rtl/calib_prescaler.sv
module calib_prescaler
    import calib_pkg::*;
#(
    parameter int unsigned PRE_W = 8,
    parameter int unsigned STG_W = 7
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     osc_tick,
    input  logic     act,
    input  cal_dir_e dir,
    output logic     sec_wrap,
    output logic     apply_done,
    output strobes_t strb
);

    localparam int unsigned HALF = 32'd1 << (PRE_W - 1);

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] blank_left;
    logic [STG_W-1:0] stg_cnt;

    logic blanking;
    logic adv;
    logic pre_last;
    logic first_period;
    logic ins_now;
    logic neg_now;
    logic stage_now;
    logic blk_now;

    always_comb begin
        blanking     = (blank_left != '0);
        adv          = osc_tick && !blanking;
        pre_last     = &pre_cnt;
        first_period = (stg_cnt == '0);
        ins_now      = adv && act && (dir == DIR_FAST) && first_period
                       && (pre_cnt == PRE_W'(HALF - 1));
        neg_now      = adv && act && (dir == DIR_SLOW) && first_period && pre_last;
        stage_now    = (adv && pre_last) || ins_now;
        sec_wrap     = adv && pre_last && (&stg_cnt);
        blk_now      = osc_tick && blanking;
        apply_done   = ins_now || neg_now;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pre_cnt    <= '0;
            stg_cnt    <= '0;
            blank_left <= '0;
            strb       <= '0;
        end else begin
            if (adv) begin
                pre_cnt <= pre_cnt + PRE_W'(1);
            end
            if (stage_now) begin
                stg_cnt <= stg_cnt + STG_W'(1);
            end
            if (neg_now) begin
                blank_left <= PRE_W'(HALF);
            end else if (blk_now) begin
                blank_left <= blank_left - PRE_W'(1);
            end
            strb.stage  <= stage_now;
            strb.second <= sec_wrap;
            strb.insert <= ins_now;
            strb.blank  <= blk_now;
        end
    end

    AST_BLANK_HOLDS_PRESCALE: assert property (@(posedge clk) disable iff (rst) (osc_tick && (blank_left != '0) && !clr) |=> ($stable(pre_cnt) && $stable(stg_cnt))); // R5
    AST_INSERT_SPLITS_FIRST_PERIOD: assert property (@(posedge clk) disable iff (rst) strb.insert |-> ((stg_cnt == STG_W'(1)) && (pre_cnt == PRE_W'(HALF)))); // R4

endmodule

// File: rtl/calib_unit.sv
module calib_unit
    import calib_pkg::*;
#(
    parameter int unsigned PRE_W = 8,
    parameter int unsigned STG_W = 7,
    parameter int unsigned CYC_W = 6,
    parameter int unsigned MAG_W = CYC_W - 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_tick,
    input  logic             chain_clear,
    input  logic             min_tick,
    input  logic [MAG_W:0]   cal_cfg,
    output logic             stage_tick,
    output logic             sec_tick,
    output logic             insert_pulse,
    output logic             blank_pulse,
    output logic [PRE_W-1:0] tap_div
);

    logic [MAG_W-1:0] mag;
    cal_dir_e         dir;
    logic             act;
    logic             sec_wrap;
    logic             apply_done;
    strobes_t         strb;

    assign mag = cal_cfg[MAG_W-1:0];
    assign dir = cal_dir_e'(cal_cfg[MAG_W]);

    calib_cycle_window #(
        .CYC_W (CYC_W),
        .MAG_W (MAG_W)
    ) window_i (
        .clk        (clk),
        .rst        (rst),
        .clr        (chain_clear),
        .min_tick   (min_tick),
        .sec_wrap   (sec_wrap),
        .apply_done (apply_done),
        .mag        (mag),
        .act        (act)
    );

    calib_prescaler #(
        .PRE_W (PRE_W),
        .STG_W (STG_W)
    ) prescale_i (
        .clk        (clk),
        .rst        (rst),
        .clr        (chain_clear),
        .osc_tick   (osc_tick),
        .act        (act),
        .dir        (dir),
        .sec_wrap   (sec_wrap),
        .apply_done (apply_done),
        .strb       (strb)
    );

    calib_tap_div #(
        .W (PRE_W)
    ) taps_i (
        .clk      (clk),
        .rst      (rst),
        .clr      (chain_clear),
        .osc_tick (osc_tick),
        .tap      (tap_div)
    );

    assign stage_tick   = strb.stage;
    assign sec_tick     = strb.second;
    assign insert_pulse = strb.insert;
    assign blank_pulse  = strb.blank;

    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(insert_pulse && blank_pulse)); // R4

endmodule

// File: tb/calib_unit_tb.sv
module calib_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int PRE_W      = 4;
    localparam int STG_W      = 3;
    localparam int CYC_W      = 4;
    localparam int MAG_W      = CYC_W - 1;
    localparam int SEC_LEN    = 1 << (PRE_W + STG_W);
    localparam int STAGES     = 1 << STG_W;
    localparam int CYC_LEN    = 1 << CYC_W;
    localparam int ELIG       = CYC_LEN - 2;
    localparam int SHORTEN    = 1 << PRE_W;
    localparam int LENGTHEN   = 1 << (PRE_W - 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             osc_tick = 1'b0;
    logic             chain_clear = 1'b0;
    logic             min_tick = 1'b0;
    logic [MAG_W:0]   cal_cfg = '0;
    logic             stage_tick;
    logic             sec_tick;
    logic             insert_pulse;
    logic             blank_pulse;
    logic [PRE_W-1:0] tap_div;

    int checks = 0;
    int errors = 0;
    int osc_cnt = 0;
    int total = 0;
    int stg_seen = 0;
    int ins_seen = 0;
    int blk_seen = 0;
    int sec_idx = 0;
    int cur_mag = 0;
    bit cur_fast = 1'b0;
    bit osc_prev = 1'b0;
    bit need_min = 1'b0;
    bit gap_phase = 1'b0;
    bit done = 1'b0;

    calib_unit #(
        .PRE_W (PRE_W),
        .STG_W (STG_W),
        .CYC_W (CYC_W)
    ) dut_i (
        .clk          (clk),
        .rst          (rst),
        .osc_tick     (osc_tick),
        .chain_clear  (chain_clear),
        .min_tick     (min_tick),
        .cal_cfg      (cal_cfg),
        .stage_tick   (stage_tick),
        .sec_tick     (sec_tick),
        .insert_pulse (insert_pulse),
        .blank_pulse  (blank_pulse),
        .tap_div      (tap_div)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (second %0d, mag %0d, fast %0d)",
                     req, act, exp, sec_idx, cur_mag, cur_fast);
        end
    endtask

    task automatic restart_counts();
        osc_cnt  = 0;
        total    = 0;
        stg_seen = 0;
        ins_seen = 0;
        blk_seen = 0;
        sec_idx  = 0;
        need_min = 1'b1;
    endtask

    task automatic eval_second();
        int  m;
        bit  adj;
        int  exp_len;
        string tag;
        m   = sec_idx % CYC_LEN;
        adj = (cur_mag != 0) && (m < 2 * cur_mag);
        exp_len = !adj ? SEC_LEN : (cur_fast ? SEC_LEN - SHORTEN : SEC_LEN + LENGTHEN);
        if (cur_mag == 0)      tag = "R6";
        else if (m >= ELIG)    tag = "R7";
        else if (adj)          tag = cur_fast ? "R3 R4" : "R3 R5";
        else                   tag = "R3";
        if (gap_phase) tag = {tag, " R10"};
        chk(osc_cnt == exp_len, {tag, " second length"}, osc_cnt, exp_len);
        chk(stg_seen == STAGES, "R2 stage ticks per second", stg_seen, STAGES);
        chk(ins_seen == ((adj && cur_fast) ? 1 : 0), "R4 insert count", ins_seen,
            (adj && cur_fast) ? 1 : 0);
        chk(blk_seen == ((adj && !cur_fast) ? LENGTHEN : 0), "R5 blank count", blk_seen,
            (adj && !cur_fast) ? LENGTHEN : 0);
        chk(tap_div == PRE_W'(total), "R9 tap counter", int'(tap_div), total % SHORTEN);
        osc_cnt  = 0;
        stg_seen = 0;
        ins_seen = 0;
        blk_seen = 0;
        sec_idx++;
        need_min = 1'b1;
    endtask

    task automatic cyc(input bit osc);
        @(negedge clk);
        if (osc_prev) begin
            osc_cnt++;
            total++;
        end
        if (stage_tick)   stg_seen++;
        if (insert_pulse) ins_seen++;
        if (blank_pulse)  blk_seen++;
        if (sec_tick)     eval_second();
        osc_tick = osc;
        osc_prev = osc;
        min_tick = need_min;
        need_min = 1'b0;
    endtask

    task automatic do_clear(input bit fast, input int mag);
        @(negedge clk);
        cal_cfg     = {fast, MAG_W'(mag)};
        cur_fast    = fast;
        cur_mag     = mag;
        chain_clear = 1'b1;
        osc_tick    = 1'b0;
        min_tick    = 1'b0;
        osc_prev    = 1'b0;
        @(negedge clk);
        chain_clear = 1'b0;
        chk(tap_div == '0, "R8 tap cleared", int'(tap_div), 0);
        chk(!stage_tick && !sec_tick && !insert_pulse && !blank_pulse,
            "R8 strobes quiet after clear",
            int'({stage_tick, sec_tick, insert_pulse, blank_pulse}), 0);
        restart_counts();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        rst = 1'b1;
        repeat (4) @(negedge clk);
        chk(tap_div == '0, "R1 tap in reset", int'(tap_div), 0);
        chk(!stage_tick && !sec_tick && !insert_pulse && !blank_pulse,
            "R1 strobes in reset",
            int'({stage_tick, sec_tick, insert_pulse, blank_pulse}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(tap_div == '0 && !sec_tick, "R1 state after release", int'(tap_div), 0);
        cur_mag  = 0;
        cur_fast = 1'b0;
        restart_counts();
        while (sec_idx < 2) cyc(1'b1);

        // R3..R9: sweep every magnitude with both signs over a full cycle and a wrap
        for (int f = 0; f < 2; f++) begin
            for (int m = 0; m < (1 << MAG_W); m++) begin
                do_clear(f[0], m);
                while (sec_idx < CYC_LEN + 2) cyc(1'b1);
            end
        end

        // R10: enable with gaps, slow and fast corrections
        gap_phase = 1'b1;
        do_clear(1'b0, 3);
        for (int k = 0; sec_idx < 8; k++) cyc((k % 3) != 0);
        do_clear(1'b1, 2);
        for (int k = 0; sec_idx < 6; k++) cyc((k % 2) == 0);

        // R8: clear in the middle of a second restarts the cycle at minute 0
        gap_phase = 1'b0;
        do_clear(1'b1, 1);
        repeat (50) cyc(1'b1);
        do_clear(1'b0, 1);
        while (sec_idx < 3) cyc(1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule